// File: doc/BRIEF.md
# Floating-point status and control register

This block holds the 32-bit status and control word of a small floating-point unit. Software writes the word through a single write port, and a write mask drops every bit that has no storage. The read port rebuilds the full word each cycle from four parts: the masked stored bits, a separately held vector length and vector stride, a sticky saturation bit, and one sticky set of cumulative exception flags.

The execution units signal events by pulsing one-cycle event vectors. Three paths report events: the single/double path, the standard-mode path and the half-precision path. A compare result, given as a two-bit relation code, overwrites only the four condition flags. The block also drives the datapath's control inputs, decoded from the stored word: rounding mode, flush-to-zero, half-precision flush-to-zero and default-NaN.

Two parameters cover reduced configurations. `REDUCED_PROFILE` removes the saturation bit, the length field, the stride field and the half-precision flush bit. `HALF_SUPPORT=0` removes only the half-precision flush bit. Trap enables are not implemented and always read as zero.

Top module: `fp_csr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_data` reads 0 and every decoded control output is 0.
- R2: A write keeps bits 31:28, 26:22 and 19 in plain storage. Bit 27 holds the saturation flag. Bits 21:20 hold the stride and bits 18:16 the length. Flags sit in bits 7 and 4:0. All other bits read 0, so writing 0xFFFFFFFF with no events reads back 0xFFFF009F.
- R3: `round_mode` drives stored bits 23:22, encoded 0 nearest-even, 1 toward +inf, 2 toward -inf, 3 toward zero. `flush_zero` drives bit 24, `default_nan` drives bit 25 and `flush_zero_half` drives bit 19. Each takes its new value in the cycle after the write.
- R4: Each event vector uses bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 input-denormal and 6 output-denormal. An event from any of the three paths sets the matching flag: invalid at bit 0, divide-by-zero at bit 1, overflow at bit 2, underflow at bit 3, inexact at bit 4, input-denormal at bit 7. The flag then stays set until a write.
- R5: An input-denormal event (event bit 5) from the half-precision path has no effect. The same event from either other path sets flag bit 7.
- R6: An output-denormal event (event bit 6) from any path sets the underflow flag, bit 3.
- R7: A write replaces all cumulative flags with the written bits 7 and 4:0. Events arriving in the same cycle are ORed in on top.
- R8: A compare with `cmp_valid` writes bits 31:28 as 0110 for equal (code 0), 1000 for less (code 1), 0010 for greater (code 2) and 0011 for unordered (code 3). It leaves every other bit unchanged. If a write arrives in the same cycle, the compare result takes bits 31:28.
- R9: Any `sat_set` pulse sets bit 27, which stays set until a write. Writing bit 27 as 0 clears it and writing it as 1 sets it.
- R10: With `REDUCED_PROFILE=1`, bit 27, bits 21:20, bits 18:16 and bit 19 always read 0, and `sat_set` has no effect.
- R11: With `HALF_SUPPORT=0`, bit 19 and `flush_zero_half` always read 0. All other fields behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 32 | Value to write |
| sd_ev | input | 7 | Event pulses, single/double path |
| std_ev | input | 7 | Event pulses, standard-mode path |
| hp_ev | input | 7 | Event pulses, half-precision path |
| sat_set | input | NUM_SAT_SRC | Saturation pulses, one per source |
| cmp_valid | input | 1 | Compare result present |
| cmp_res | input | 2 | Compare relation code |
| rd_data | output | 32 | Assembled architectural word |
| round_mode | output | 2 | Rounding mode to the datapath |
| flush_zero | output | 1 | Flush-to-zero enable |
| flush_zero_half | output | 1 | Half-precision flush-to-zero enable |
| default_nan | output | 1 | Default-NaN enable |

## Verification
Every source of state here is a single register stage: a write, an event pulse, a saturation pulse or a compare. The result therefore appears on `rd_data` and on the control outputs exactly one clock after the edge that samples the stimulus. The read path adds no delay. The bench applies each stimulus on a falling edge and removes it on the next falling edge, then samples there, half a period after the one rising edge that captures it. Stickiness is checked by sampling again after idle cycles.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;

   localparam int WORD_W     = 32;
   localparam int NUM_EV     = 7;
   localparam int NUM_FLAGS  = 6;
   localparam int NUM_UNITS  = 3;
   localparam int HALF_UNIT  = 2;

   // event vector positions
   localparam int EV_INV = 0;
   localparam int EV_DZ  = 1;
   localparam int EV_OF  = 2;
   localparam int EV_UF  = 3;
   localparam int EV_IX  = 4;
   localparam int EV_IDN = 5;
   localparam int EV_ODN = 6;

   // word field positions
   localparam int NZCV_LSB   = 28;
   localparam int SAT_BIT    = 27;
   localparam int DN_BIT     = 25;
   localparam int FZ_BIT     = 24;
   localparam int RM_LSB     = 22;
   localparam int STRIDE_LSB = 20;
   localparam int FZH_BIT    = 19;
   localparam int LEN_LSB    = 16;
   localparam int LEN_W      = 3;
   localparam int STRIDE_W   = 2;
   localparam int IDN_POS    = 7;

   localparam logic [WORD_W-1:0] SIDE_FIELDS = 32'h0837_00FF;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_LT = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } cmp_rel_e;

endpackage

// File: rtl/fp_csr_flags.sv
module fp_csr_flags
   import fp_csr_pkg::*;
#(
   parameter int UNITS    = NUM_UNITS,
   parameter int HALF_IDX = HALF_UNIT
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [NUM_FLAGS-1:0]              wr_flags,
   input  logic [UNITS-1:0][NUM_EV-1:0]      unit_ev,
   output logic [NUM_FLAGS-1:0]              flags_q
);

   logic [UNITS-1:0][NUM_FLAGS-1:0] raised;
   logic [NUM_FLAGS-1:0]            raised_any;

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      logic idn_in;
      if (u == HALF_IDX) begin : g_half
         assign idn_in = 1'b0;
      end else begin : g_full
         assign idn_in = unit_ev[u][EV_IDN];
      end
      assign raised[u] = {idn_in,
                          unit_ev[u][EV_IX],
                          unit_ev[u][EV_UF] | unit_ev[u][EV_ODN],
                          unit_ev[u][EV_OF],
                          unit_ev[u][EV_DZ],
                          unit_ev[u][EV_INV]};
   end

   always_comb begin
      raised_any = '0;
      for (int u = 0; u < UNITS; u++) begin
         raised_any = raised_any | raised[u];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         flags_q <= (wr_en ? wr_flags : flags_q) | raised_any;
      end
   end

endmodule

// File: rtl/fp_csr_cmp_enc.sv
module fp_csr_cmp_enc
   import fp_csr_pkg::*;
(
   input  logic [1:0] rel,
   output logic [3:0] nzcv
);

   always_comb begin
      unique case (cmp_rel_e'(rel))
         REL_EQ:  nzcv = 4'b0110;
         REL_LT:  nzcv = 4'b1000;
         REL_GT:  nzcv = 4'b0010;
         default: nzcv = 4'b0011;
      endcase
   end

endmodule

// File: rtl/fp_csr_store.sv
module fp_csr_store
   import fp_csr_pkg::*;
#(
   parameter logic [WORD_W-1:0] KEEP_MASK = 32'hF7C8_0000,
   parameter bit                REDUCED   = 1'b0,
   parameter bit                HALF_OK   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                cmp_valid,
   input  logic [3:0]          nzcv,
   input  logic                sat_any,
   output logic [WORD_W-1:0]   word_q,
   output logic [LEN_W-1:0]    len_q,
   output logic [STRIDE_W-1:0] stride_q,
   output logic                sat_q
);

   localparam bit DROP_FZH = REDUCED || !HALF_OK;
   localparam logic [WORD_W-1:0] FZH_ONE  = WORD_W'(1) << FZH_BIT;
   localparam logic [WORD_W-1:0] EFF_MASK = DROP_FZH ? (KEEP_MASK & ~FZH_ONE) : KEEP_MASK;

   logic [WORD_W-1:0] word_d;

   always_comb begin
      word_d = wr_en ? (wr_data & EFF_MASK) : word_q;
      if (cmp_valid) begin
         word_d[NZCV_LSB +: 4] = nzcv;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else begin
         word_q <= word_d;
      end
   end

   if (REDUCED) begin : g_reduced
      assign len_q    = '0;
      assign stride_q = '0;
      assign sat_q    = 1'b0;
   end else begin : g_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_q    <= '0;
            stride_q <= '0;
            sat_q    <= 1'b0;
         end else begin
            if (wr_en) begin
               len_q    <= wr_data[LEN_LSB +: LEN_W];
               stride_q <= wr_data[STRIDE_LSB +: STRIDE_W];
            end
            sat_q <= (wr_en ? wr_data[SAT_BIT] : sat_q) | sat_any;
         end
      end
   end

endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit
   import fp_csr_pkg::*;
#(
   parameter logic [31:0] STORE_MASK      = 32'hF7C8_0000,
   parameter bit          REDUCED_PROFILE = 1'b0,
   parameter bit          HALF_SUPPORT    = 1'b1,
   parameter int          NUM_SAT_SRC     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [31:0]            wr_data,
   input  logic [6:0]             sd_ev,
   input  logic [6:0]             std_ev,
   input  logic [6:0]             hp_ev,
   input  logic [NUM_SAT_SRC-1:0] sat_set,
   input  logic                   cmp_valid,
   input  logic [1:0]             cmp_res,
   output logic [31:0]            rd_data,
   output logic [1:0]             round_mode,
   output logic                   flush_zero,
   output logic                   flush_zero_half,
   output logic                   default_nan
);

   if ((STORE_MASK & SIDE_FIELDS) != 0) begin : g_bad_mask
      $error("STORE_MASK overlaps separately held fields");
   end
   if (NUM_SAT_SRC < 1) begin : g_bad_sat
      $error("NUM_SAT_SRC must be at least 1");
   end

   logic [NUM_UNITS-1:0][NUM_EV-1:0] unit_ev;
   logic [NUM_FLAGS-1:0]             flags_q;
   logic [3:0]                       nzcv;
   logic [WORD_W-1:0]                word_q;
   logic [LEN_W-1:0]                 len_q;
   logic [STRIDE_W-1:0]              stride_q;
   logic                             sat_q;

   assign unit_ev = {hp_ev, std_ev, sd_ev};

   fp_csr_flags #(
      .UNITS    (NUM_UNITS),
      .HALF_IDX (HALF_UNIT)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_flags ({wr_data[IDN_POS], wr_data[4:0]}),
      .unit_ev  (unit_ev),
      .flags_q  (flags_q)
   );

   fp_csr_cmp_enc u_cmp (
      .rel  (cmp_res),
      .nzcv (nzcv)
   );

   fp_csr_store #(
      .KEEP_MASK (STORE_MASK),
      .REDUCED   (REDUCED_PROFILE),
      .HALF_OK   (HALF_SUPPORT)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .cmp_valid (cmp_valid),
      .nzcv      (nzcv),
      .sat_any   (|sat_set),
      .word_q    (word_q),
      .len_q     (len_q),
      .stride_q  (stride_q),
      .sat_q     (sat_q)
   );

   always_comb begin
      rd_data                          = word_q;
      rd_data[SAT_BIT]                 = sat_q;
      rd_data[STRIDE_LSB +: STRIDE_W]  = stride_q;
      rd_data[LEN_LSB +: LEN_W]        = len_q;
      rd_data[IDN_POS]                 = flags_q[5];
      rd_data[4:0]                     = flags_q[4:0];
   end

   assign round_mode      = word_q[RM_LSB +: 2];
   assign flush_zero      = word_q[FZ_BIT];
   assign flush_zero_half = word_q[FZH_BIT];
   assign default_nan     = word_q[DN_BIT];

endmodule

// File: rtl/fp_csr_unit_chk.sv
module fp_csr_unit_chk #(
   parameter bit REDUCED_PROFILE = 1'b0,
   parameter int NUM_SAT_SRC     = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [31:0]            wr_data,
   input logic [6:0]             sd_ev,
   input logic [6:0]             std_ev,
   input logic [6:0]             hp_ev,
   input logic [NUM_SAT_SRC-1:0] sat_set,
   input logic                   cmp_valid,
   input logic [31:0]            rd_data,
   input logic [1:0]             round_mode,
   input logic                   flush_zero,
   input logic                   default_nan
);

   logic no_ev;
   assign no_ev = !(|sd_ev) && !(|std_ev) && !(|hp_ev);

   assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & 32'h0000_FF60) == 32'h0)
      else $error("unbacked bits read nonzero");

   assert_ctrl_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (round_mode == $past(wr_data[23:22])) &&
                (flush_zero == $past(wr_data[24])) &&
                (default_nan == $past(wr_data[25])))
      else $error("control outputs do not follow write");

   assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (($past(rd_data) & 32'h0000_009F) & ~rd_data) == 32'h0)
      else $error("flag dropped without a write");

   assert_write_replace_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && no_ev) |=> ({rd_data[7], rd_data[4:0]} == $past({wr_data[7], wr_data[4:0]})))
      else $error("write did not replace flags");

   assert_nzcv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !cmp_valid) |=> $stable(rd_data[31:28]))
      else $error("condition flags changed without cause");

   assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!REDUCED_PROFILE && !wr_en && (|sat_set)) |=> rd_data[27])
      else $error("saturation pulse not recorded");

   assert_reduced_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      REDUCED_PROFILE |-> (rd_data & 32'h083F_0000) == 32'h0)
      else $error("reduced fields nonzero");

endmodule

bind fp_csr_unit fp_csr_unit_chk #(
   .REDUCED_PROFILE (REDUCED_PROFILE),
   .NUM_SAT_SRC     (NUM_SAT_SRC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .sd_ev       (sd_ev),
   .std_ev      (std_ev),
   .hp_ev       (hp_ev),
   .sat_set     (sat_set),
   .cmp_valid   (cmp_valid),
   .rd_data     (rd_data),
   .round_mode  (round_mode),
   .flush_zero  (flush_zero),
   .default_nan (default_nan)
);

// File: tb/fp_csr_unit_test.sv
module fp_csr_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [6:0]  sd_ev = '0;
   logic [6:0]  std_ev = '0;
   logic [6:0]  hp_ev = '0;
   logic [3:0]  sat_set = '0;
   logic        cmp_valid = 1'b0;
   logic [1:0]  cmp_res = '0;

   logic [31:0] rd_a, rd_r, rd_h;
   logic [1:0]  rm_a, rm_r, rm_h;
   logic        fz_a, fz_r, fz_h;
   logic        fzh_a, fzh_r, fzh_h;
   logic        dn_a, dn_r, dn_h;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fp_csr_unit uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sd_ev(sd_ev), .std_ev(std_ev), .hp_ev(hp_ev), .sat_set(sat_set),
      .cmp_valid(cmp_valid), .cmp_res(cmp_res),
      .rd_data(rd_a), .round_mode(rm_a), .flush_zero(fz_a),
      .flush_zero_half(fzh_a), .default_nan(dn_a));

   fp_csr_unit #(.REDUCED_PROFILE(1'b1)) uut_rp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sd_ev(sd_ev), .std_ev(std_ev), .hp_ev(hp_ev), .sat_set(sat_set),
      .cmp_valid(cmp_valid), .cmp_res(cmp_res),
      .rd_data(rd_r), .round_mode(rm_r), .flush_zero(fz_r),
      .flush_zero_half(fzh_r), .default_nan(dn_r));

   fp_csr_unit #(.HALF_SUPPORT(1'b0)) uut_nh (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sd_ev(sd_ev), .std_ev(std_ev), .hp_ev(hp_ev), .sat_set(sat_set),
      .cmp_valid(cmp_valid), .cmp_res(cmp_res),
      .rd_data(rd_h), .round_mode(rm_h), .flush_zero(fz_h),
      .flush_zero_half(fzh_h), .default_nan(dn_h));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // stimulus is set at a falling edge; this captures it and returns at the next falling edge
   task automatic step();
      @(negedge clk);
      wr_en = 1'b0; cmp_valid = 1'b0; sd_ev = '0; std_ev = '0; hp_ev = '0; sat_set = '0;
   endtask

   task automatic write(input logic [31:0] v);
      wr_en = 1'b1; wr_data = v;
      step();
   endtask

   task automatic t_reset();
      check("R1 rd", rd_a, 32'h0);
      check("R1 ctrl", {27'h0, rm_a, fz_a, fzh_a, dn_a}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", rd_a, 32'h0);
   endtask

   task automatic t_mask();
      write(32'hFFFF_FFFF);
      check("R2 full write", rd_a, 32'hFFFF_009F);
      check("R10 reduced full write", rd_r, 32'hF7C0_009F);
      check("R11 no-half full write", rd_h, 32'hFFF7_009F);
      check("R11 no-half fzh", {31'h0, fzh_h}, 32'h0);
      write(32'h0035_0000);
      check("R2 len stride", rd_a, 32'h0035_0000);
      check("R10 reduced len stride", rd_r, 32'h0);
      write(32'h0);
      check("R7 clear", rd_a, 32'h0);
   endtask

   task automatic t_ctrl();
      for (int m = 0; m < 4; m++) begin
         logic [31:0] v;
         v = (32'(m) << 22) | ((m[0]) ? 32'h0100_0000 : 32'h0) |
             ((m[1]) ? 32'h0200_0000 : 32'h0) | ((m == 2) ? 32'h0008_0000 : 32'h0);
         write(v);
         check("R3 decode", {27'h0, rm_a, fz_a, fzh_a, dn_a},
               {27'h0, 2'(m), m[0], (m == 2), m[1]});
         check("R3 readback", rd_a, v);
      end
      write(32'h0);
   endtask

   task automatic t_flags();
      sd_ev = 7'b000_0001; step();
      check("R4 sd invalid", rd_a, 32'h01);
      std_ev = 7'b000_0100; step();
      check("R4 std overflow", rd_a, 32'h05);
      step(); step();
      check("R4 sticky idle", rd_a, 32'h05);
      hp_ev = 7'b001_0000; step();
      check("R4 hp inexact", rd_a, 32'h15);
      hp_ev = 7'b010_0000; step();
      check("R5 hp input-denormal ignored", rd_a, 32'h15);
      std_ev = 7'b010_0000; step();
      check("R5 std input-denormal", rd_a, 32'h95);
      hp_ev = 7'b100_0000; step();
      check("R6 output-denormal to underflow", rd_a, 32'h9D);
      write(32'h0);
      sd_ev = 7'b100_0000; step();
      check("R6 sd output-denormal", rd_a, 32'h08);
   endtask

   task automatic t_replace();
      wr_en = 1'b1; wr_data = 32'h0000_0010; hp_ev = 7'b000_0010;
      step();
      check("R7 write plus same-cycle event", rd_a, 32'h12);
      write(32'h0000_0081);
      check("R7 write replaces", rd_a, 32'h81);
      write(32'h0);
   endtask

   task automatic t_cmp();
      write(32'h00C0_0003);
      cmp_valid = 1'b1; cmp_res = 2'd0; step();
      check("R8 equal", rd_a, 32'h60C0_0003);
      cmp_valid = 1'b1; cmp_res = 2'd1; step();
      check("R8 less", rd_a, 32'h80C0_0003);
      cmp_valid = 1'b1; cmp_res = 2'd2; step();
      check("R8 greater", rd_a, 32'h20C0_0003);
      cmp_valid = 1'b1; cmp_res = 2'd3; step();
      check("R8 unordered", rd_a, 32'h30C0_0003);
      wr_en = 1'b1; wr_data = 32'hF000_0000; cmp_valid = 1'b1; cmp_res = 2'd1;
      step();
      check("R8 compare beats write", rd_a, 32'h8000_0000);
      write(32'h0);
   endtask

   task automatic t_sat();
      sat_set = 4'b0100; step();
      check("R9 saturation set", rd_a, 32'h0800_0000);
      check("R10 reduced ignores saturation", rd_r, 32'h0);
      step();
      check("R9 saturation sticky", rd_a, 32'h0800_0000);
      write(32'h0);
      check("R9 write clears", rd_a, 32'h0);
      write(32'h0800_0000);
      check("R9 write sets", rd_a, 32'h0800_0000);
      write(32'h0);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_mask();
      t_ctrl();
      t_flags();
      t_replace();
      t_cmp();
      t_sat();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule